// File: doc/BRIEF.md
# SMBus Indexed Block-Access Register Slave

This block is a two-wire serial slave that holds a small bank of 8-bit control registers and presents them on a flat parallel output, so that clock-control logic can use them directly. A host writes the registers with an indexed block write. The host sends the slave address with the write bit, a starting index, a byte count and then the data bytes. The slave stores the data bytes at consecutive locations.

To read, the host sends the write address and an index, then a repeated start and the read address. The slave answers with a count byte, taken from a designated register, and then with register contents from the index onward. It keeps sending until the host withholds its acknowledge.

Both bus lines are brought into the system clock domain through a synchroniser. Start and stop conditions, and SCL edges, are found on the synchronised copies. The slave pulls SDA only through an open-drain enable, for acknowledges and for read data.

Top module: `smb_blkreg_slave`

## Requirements
- R1: The address byte `{DEV_ADDR,0}` (0xD2 by default) is acknowledged and starts a write. The address byte `{DEV_ADDR,1}` (0xD3 by default) is acknowledged and starts a read. Bytes travel MSB first, and an acknowledge is SDA held low for the ninth SCL pulse.
- R2: Any other address byte is not acknowledged. Until the next start condition the slave never drives SDA and changes no register.
- R3: In a write, the byte after the address is the index N and the next byte is the count X. The X data bytes that follow are stored at N through N+X-1. The address, index, count and data bytes are all acknowledged.
- R4: Data bytes sent after X bytes have been counted are acknowledged but not stored.
- R5: Writes to an index at or above DEPTH are acknowledged and have no effect. Reads from such an index return 0x00.
- R6: In a read, the slave first sends the count byte. It then sends the register at the index set by the preceding write phase, and the index steps up by one for each further byte.
- R7: The count byte comes from register CNT_LOC (index 8 by default). Writing that register changes the count returned by later reads.
- R8: A not-acknowledge from the host after a read byte makes the slave release SDA. It then stays off the bus until the next start condition.
- R9: A stop condition at any point ends the transfer. A partly received byte is dropped and the slave returns to idle.
- R10: After reset, register CNT_LOC holds CNT_RST (8), every other register holds zero, and SDA is released.
- R11: The SDA drive enable changes only while SCL is low. An acknowledge is held through the whole SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When 1, pull SDA low |
| regs_o | output | DEPTH*8 | Register bank; register k sits in bits [8k+7:8k] |

## Verification
The bench uses a wired-AND model of the bus. It targets the index boundary: a write that starts two below DEPTH, and a read that runs past the last register. A design with a wrong bound would either overwrite low registers as the index wraps or return stale data instead of zero. The bench also sends extra bytes past the count, which a slave that ignores the count would store. It sends a count-register write followed by a read, which shows whether the count byte is hardwired. A stop halfway through a byte exposes designs that commit partial data. A wrong address, and a host NACK followed by more clocks, catch a slave that keeps driving SDA when it should have let go of the bus.

// File: rtl/smb_pkg.sv
// Shared types for the serial register slave.
package smb_pkg;
    // Bus-level phase of the slave
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a start condition
        ST_RX,      // shifting in a byte from the host
        ST_RACK,    // slave drives ACK for the ninth pulse
        ST_TX,      // slave shifts a byte out
        ST_HACK     // host acknowledge slot after a sent byte
    } smb_state_e;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        RB_ADDR,
        RB_IDX,
        RB_CNT,
        RB_DATA
    } smb_rxrole_e;
endpackage

// File: rtl/smb_line_sync.sv
// Brings SCL/SDA into the clk domain and flags bus events.
// Assumes both lines stay stable for several clk periods around every edge.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;
    logic              scl_s;

    // Shift raw lines through the synchroniser chain and keep one delayed copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    // Decode edges and start/stop from the current and previous samples
    always_comb begin
        scl_s   = scl_q[STAGES-1];
        sda_o   = sda_q[STAGES-1];
        start_o = scl_d & scl_s & sda_d & ~sda_o;
        stop_o  = scl_d & scl_s & ~sda_d & sda_o;
        rise_o  = ~scl_d & scl_s;
        fall_o  = scl_d & ~scl_s;
    end
endmodule

// File: rtl/smb_regbank.sv
// Bank of DEPTH 8-bit registers with one write port and one read port.
// Location CNT_LOC resets to CNT_RST and all others reset to zero.
// Addresses at or above DEPTH match no register and read as zero.
module smb_regbank #(
    parameter int         DEPTH   = 16,
    parameter int         CNT_LOC = 8,
    parameter logic [7:0] CNT_RST = 8'h08
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [7:0]         waddr,
    input  logic [7:0]         wdata,
    input  logic [7:0]         raddr,
    output logic [7:0]         rdata,
    output logic [7:0]         cnt_o,
    output logic [DEPTH*8-1:0] regs_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        localparam logic [7:0] RST_VAL = (g == CNT_LOC) ? CNT_RST : 8'h00;
        // Hold one register, loaded when the write address selects it
        always_ff @(posedge clk) begin
            if (!rst_n)                      mem[g] <= RST_VAL;
            else if (we && waddr == 8'(g))   mem[g] <= wdata;
        end
        assign regs_o[g*8 +: 8] = mem[g];
    end

    // Read mux with zero beyond the last register
    always_comb begin
        rdata = (int'(raddr) < DEPTH) ? mem[raddr[AW-1:0]] : 8'h00;
        cnt_o = mem[CNT_LOC];
    end
endmodule

// File: rtl/smb_blkreg_slave.sv
// Indexed block-access register slave on a two-wire bus.
// Write: S, {DEV_ADDR,0}, index, count, data...  P
// Read:  S, {DEV_ADDR,0}, index, Sr, {DEV_ADDR,1}, then count byte and data until NACK.
// Assumes SCL high and low phases last several clk periods longer than the synchroniser delay.
module smb_blkreg_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         DEPTH       = 16,
    parameter int         CNT_LOC     = 8,
    parameter logic [7:0] CNT_RST     = 8'h08,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    output logic [DEPTH*8-1:0] regs_o
);
    import smb_pkg::*;

    logic sda_s, start_ev, stop_ev, rise_ev, fall_ev;

    smb_state_e  state_q;
    smb_rxrole_e role_q;
    logic [7:0]  shreg_q, txsh_q, ptr_q, rem_q;
    logic [3:0]  bitcnt_q;
    logic        go_tx_q, first_q, hack_ok_q, oe_q;
    logic        we;
    logic [7:0]  rdata, cnt_val, txbyte;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .start_o(start_ev), .stop_o(stop_ev),
        .rise_o(rise_ev), .fall_o(fall_ev)
    );

    smb_regbank #(.DEPTH(DEPTH), .CNT_LOC(CNT_LOC), .CNT_RST(CNT_RST)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr_q), .wdata(shreg_q),
        .raddr(ptr_q), .rdata(rdata), .cnt_o(cnt_val), .regs_o(regs_o)
    );

    // Write strobe at the end of a data byte that is still inside the count
    always_comb begin
        we = (state_q == ST_RX) && fall_ev && (bitcnt_q == 4'd8) &&
             (role_q == RB_DATA) && (rem_q != 8'd0) && !stop_ev && !start_ev;
        txbyte = first_q ? cnt_val : rdata;
    end

    // Bus protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            role_q    <= RB_ADDR;
            shreg_q   <= '0;
            txsh_q    <= '0;
            ptr_q     <= '0;
            rem_q     <= '0;
            bitcnt_q  <= '0;
            go_tx_q   <= 1'b0;
            first_q   <= 1'b0;
            hack_ok_q <= 1'b0;
            oe_q      <= 1'b0;
        end else if (stop_ev) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
        end else if (start_ev) begin
            state_q  <= ST_RX;
            role_q   <= RB_ADDR;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RX: begin
                    if (rise_ev && bitcnt_q < 4'd8) begin
                        shreg_q  <= {shreg_q[6:0], sda_s};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (fall_ev && bitcnt_q == 4'd8) begin
                        bitcnt_q <= '0;
                        oe_q     <= 1'b1;
                        state_q  <= ST_RACK;
                        go_tx_q  <= 1'b0;
                        unique case (role_q)
                            RB_ADDR: begin
                                if (shreg_q[7:1] == DEV_ADDR) begin
                                    go_tx_q <= shreg_q[0];
                                    first_q <= 1'b1;
                                    role_q  <= RB_IDX;
                                end else begin
                                    oe_q    <= 1'b0;
                                    state_q <= ST_IDLE;
                                end
                            end
                            RB_IDX: begin
                                ptr_q  <= shreg_q;
                                role_q <= RB_CNT;
                            end
                            RB_CNT: begin
                                rem_q  <= shreg_q;
                                role_q <= RB_DATA;
                            end
                            RB_DATA: begin
                                ptr_q <= ptr_q + 8'd1;
                                if (rem_q != 8'd0) rem_q <= rem_q - 8'd1;
                            end
                        endcase
                    end
                end
                ST_RACK, ST_HACK: begin
                    if (state_q == ST_HACK && rise_ev) begin
                        hack_ok_q <= ~sda_s;
                    end else if (fall_ev) begin
                        if ((state_q == ST_RACK && go_tx_q) ||
                            (state_q == ST_HACK && hack_ok_q)) begin
                            txsh_q   <= txbyte;
                            oe_q     <= ~txbyte[7];
                            bitcnt_q <= 4'd1;
                            first_q  <= 1'b0;
                            state_q  <= ST_TX;
                            if (!first_q) ptr_q <= ptr_q + 8'd1;
                        end else begin
                            oe_q    <= 1'b0;
                            state_q <= (state_q == ST_RACK) ? ST_RX : ST_IDLE;
                        end
                    end
                end
                ST_TX: begin
                    if (fall_ev) begin
                        if (bitcnt_q == 4'd8) begin
                            oe_q      <= 1'b0;
                            hack_ok_q <= 1'b0;
                            state_q   <= ST_HACK;
                        end else begin
                            oe_q     <= ~txsh_q[6];
                            txsh_q   <= {txsh_q[6:0], 1'b0};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = oe_q;
endmodule

// File: rtl/smb_blkreg_chk.sv
// Protocol checker for the register slave, attached by bind.
module smb_blkreg_chk #(
    parameter int DEPTH = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_i,
    input logic                sda_oe_o,
    input logic [DEPTH*8-1:0]  regs_o,
    input logic                fall_ev,
    input logic                stop_ev,
    input smb_pkg::smb_state_e state_q
);
    // R11
    oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe_o);

    // R3
    reg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> $past(fall_ev));

    // R8
    drive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (state_q == smb_pkg::ST_RACK || state_q == smb_pkg::ST_TX));
endmodule

bind smb_blkreg_slave smb_blkreg_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .regs_o(regs_o), .fall_ev(fall_ev), .stop_ev(stop_ev), .state_q(state_q)
);

// File: tb/smb_blkreg_slave_bench.sv
// Bench: bit-level host model on a wired-AND bus, directed corners plus seeded random traffic.
module smb_blkreg_slave_bench;
    localparam int DEPTH = 16;
    localparam int CNT_LOC = 8;
    localparam int H = 12;
    localparam int Q = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_low = 1'b0;
    logic dut_oe;
    logic sda_line;
    logic [DEPTH*8-1:0] regs;

    int total = 0;
    int fails = 0;
    logic [7:0] mdl [DEPTH];
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];
    bit oe_seen;

    always #10 clk = ~clk;
    assign sda_line = ~(host_low | dut_oe);

    smb_blkreg_slave u_smb_blkreg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(dut_oe), .regs_o(regs)
    );

    always @(negedge clk) if (dut_oe) oe_seen = 1'b1;

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        int bad = -1;
        for (int i = 0; i < DEPTH; i++)
            if (bad < 0 && regs[i*8 +: 8] !== mdl[i]) bad = i;
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, {tag, " reg mismatch"}, int'(regs[bad*8 +: 8]), int'(mdl[bad]));
    endtask

    task automatic bus_start();
        wt(Q); host_low = 1'b0; wt(H - Q); scl = 1'b1; wt(H); host_low = 1'b1; wt(H); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wt(Q); host_low = 1'b1; wt(H - Q); scl = 1'b1; wt(H); host_low = 1'b0; wt(H);
    endtask

    task automatic send_bit(input bit b);
        wt(Q); host_low = ~b; wt(H - Q); scl = 1'b1; wt(H); scl = 1'b0;
    endtask

    task automatic recv_bit(output bit b);
        wt(Q); host_low = 1'b0; wt(H - Q); scl = 1'b1; wt(H / 2); b = sda_line; wt(H - H / 2); scl = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(s);
        ack = ~s;
    endtask

    task automatic rd_byte(output logic [7:0] v, input bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) begin recv_bit(s); v[i] = s; end
        send_bit(~ack);
    endtask

    // Full block write; n data bytes from wbuf, count field cnt
    task automatic do_write(input int idx, input int cnt, input int n, output bit all_ack);
        bit a;
        all_ack = 1'b1;
        bus_start();
        wr_byte(8'hD2, a); all_ack &= a;
        wr_byte(8'(idx), a); all_ack &= a;
        wr_byte(8'(cnt), a); all_ack &= a;
        for (int i = 0; i < n; i++) begin wr_byte(wbuf[i], a); all_ack &= a; end
        bus_stop();
    endtask

    // Full block read; n data bytes into rbuf after the count byte
    task automatic do_read(input int idx, input int n, output logic [7:0] cntb, output bit all_ack);
        bit a;
        all_ack = 1'b1;
        bus_start();
        wr_byte(8'hD2, a); all_ack &= a;
        wr_byte(8'(idx), a); all_ack &= a;
        bus_start();
        wr_byte(8'hD3, a); all_ack &= a;
        rd_byte(cntb, n != 0);
        for (int i = 0; i < n; i++) rd_byte(rbuf[i], i != n - 1);
        bus_stop();
    endtask

    function automatic void mdl_write(input int idx, input int cnt, input int n);
        int p = idx;
        int r = cnt;
        for (int i = 0; i < n; i++) begin
            if (r != 0 && p < DEPTH) mdl[p] = wbuf[i];
            if (r != 0) r--;
            p++;
        end
    endfunction

    function automatic logic [7:0] mdl_rd(input int p);
        return (p < DEPTH) ? mdl[p] : 8'h00;
    endfunction

    task automatic read_and_check(input int idx, input int n, input string tag);
        logic [7:0] cb;
        bit ak;
        int bad;
        do_read(idx, n, cb, ak);
        chk(ak, {tag, " R1 read address/index ack"}, int'(ak), 1);
        chk(cb == mdl[CNT_LOC], {tag, " R7 count byte"}, int'(cb), int'(mdl[CNT_LOC]));
        bad = -1;
        for (int i = 0; i < n; i++) if (bad < 0 && rbuf[i] !== mdl_rd(idx + i)) bad = i;
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, {tag, " R6 read data"}, int'(rbuf[bad]), int'(mdl_rd(idx + bad)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        bit ak;
        logic [7:0] cb;
        void'($urandom(32'd1357));
        for (int i = 0; i < DEPTH; i++) mdl[i] = (i == CNT_LOC) ? 8'h08 : 8'h00;
        wt(5);
        rst_n = 1'b1;
        wt(5);

        // R10 reset values and released line
        chk_regs("R10 reset");
        chk(dut_oe == 1'b0, "R10 sda released", int'(dut_oe), 0);

        // R3 directed write of three bytes at index 2
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
        do_write(2, 3, 3, ak);
        mdl_write(2, 3, 3);
        chk(ak, "R1 R3 write acks", int'(ak), 1);
        chk_regs("R3 write stored");

        // R6 read back from index 2, MSB first, count byte first
        read_and_check(2, 3, "R6 directed");

        // R2 wrong address: no ack, no drive, no change
        oe_seen = 1'b0;
        bus_start();
        wr_byte(8'hA0, ak);
        chk(!ak, "R2 foreign address nack", int'(ak), 0);
        wr_byte(8'h00, ak); wr_byte(8'h01, ak); wr_byte(8'h55, ak);
        bus_stop();
        chk(!oe_seen, "R2 line untouched", int'(oe_seen), 0);
        chk_regs("R2 regs unchanged");

        // R4 bytes past the count are acked, not stored
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(5, 1, 3, ak);
        mdl_write(5, 1, 3);
        chk(ak, "R4 extra bytes acked", int'(ak), 1);
        chk_regs("R4 extra bytes dropped");

        // R5 write running off the end of the bank, then read past it
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3; wbuf[3] = 8'hC4;
        do_write(DEPTH - 2, 4, 4, ak);
        mdl_write(DEPTH - 2, 4, 4);
        chk(ak, "R5 out-of-range write acked", int'(ak), 1);
        chk_regs("R5 out-of-range write ignored");
        read_and_check(DEPTH - 1, 3, "R5 read past end");

        // R7 changing the count register changes the returned count
        wbuf[0] = 8'h03;
        do_write(CNT_LOC, 1, 1, ak);
        mdl_write(CNT_LOC, 1, 1);
        read_and_check(0, 2, "R7 new count");

        // R8 host NACK on count byte, then more clocks: line must stay free
        do_read(0, 0, cb, ak);
        chk(cb == mdl[CNT_LOC], "R8 count before nack", int'(cb), int'(mdl[CNT_LOC]));
        oe_seen = 1'b0;
        bus_start();
        wr_byte(8'hD3, ak);
        rd_byte(cb, 1'b0);
        oe_seen = 1'b0;
        for (int i = 0; i < 9; i++) begin bit s; recv_bit(s); end
        bus_stop();
        chk(!oe_seen, "R8 released after nack", int'(oe_seen), 0);

        // R9 stop halfway through a data byte
        bus_start();
        wr_byte(8'hD2, ak); wr_byte(8'd3, ak); wr_byte(8'd2, ak); wr_byte(8'h77, ak);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        wbuf[0] = 8'h77;
        mdl_write(3, 2, 1);
        chk_regs("R9 partial byte dropped");
        chk(dut_oe == 1'b0, "R9 idle after stop", int'(dut_oe), 0);
        read_and_check(3, 2, "R9 fresh transfer after abort");

        // Seeded random traffic, R3 R4 R5 R6 R7
        for (int it = 0; it < 12; it++) begin
            int idx = $urandom_range(0, DEPTH + 1);
            int cnt = $urandom_range(0, 4);
            int n = cnt + $urandom_range(0, 1);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(idx, cnt, n, ak);
            mdl_write(idx, cnt, n);
            chk(ak, "R3 random write acks", int'(ak), 1);
            chk_regs("R3 random write");
            read_and_check($urandom_range(0, DEPTH), $urandom_range(1, 4), "R6 random read");
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule